// File: doc/BRIEF.md
# Float Compare-to-Zero Flag Unit

This block is the execution slice of a floating-point pipe that tests one single-precision register against zero. Each cycle it may receive a 16-bit instruction word with a valid strobe. When the word carries the compare-to-zero opcode, the low three bits pick one of eight 32-bit source registers. The unit sorts the operand into zero, positive or negative and writes the result into two flags of a seven-flag status register. The other five flags keep their values.

The classification follows a small set of rules. Any operand whose exponent field is all zeros counts as exactly zero: both signed zeros and every denormal of either sign. A NaN counts as an infinity of its own sign, so it never gives the zero result. Apart from that, only the sign bit decides between positive and negative.

The source registers sit in a small register file inside the block. A write port lets the surrounding pipe, or a testbench, load values into it. The status register is the block's only output.

Top module: `fzcmp_unit`

## Requirements
- R1: An instruction executes only when instr_valid is high and instr_word[15:3] equals 13'b1110010110100 (the word is 0xE5A0 plus the selector).
- R2: An operand whose exponent field (bits 30:23) is zero gives zero flag 1 and negative flag 0. This covers 0x00000000, 0x80000000 and denormals of either sign.
- R3: An operand with a nonzero exponent and sign bit 0 gives zero flag 0 and negative flag 0. This covers finite values, +infinity and positive-signed NaN.
- R4: An operand with a nonzero exponent and sign bit 1 gives zero flag 0 and negative flag 1. This covers -infinity.
- R5: A NaN (exponent 0xFF, mantissa nonzero) is classified as an infinity that keeps its sign bit.
- R6: The status layout is bit0 overflow latch, bit1 underflow latch, bit2 negative flag, bit3 zero flag, bit4 integer-negative, bit5 integer-zero, bit6 test flag. An executed instruction writes only bits 3 and 2.
- R7: A word that fails the opcode match, or any word presented with instr_valid low, leaves all seven status bits unchanged.
- R8: The flags from an instruction presented before a clock edge are visible on status_q right after that edge, so a result takes one cycle.
- R9: A synchronous active-high rst clears status_q to 0 at the next clock edge.
- R10: instr_word[2:0] selects the source register. A register write (wr_en, wr_addr, wr_data) takes effect at the clock edge, so an instruction in the same cycle reads the register's previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status register |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 3 | Register file write index |
| wr_data | input | 32 | Register file write value |
| instr_valid | input | 1 | Instruction word valid |
| instr_word | input | 16 | Instruction word |
| status_q | output | 7 | Floating-point status flags |

## Verification
The assertions check on every cycle:
- the flag outcome for each of the three operand classes, from the operand read out of the register file;
- that the status register holds still whenever no instruction executes;
- that the five foreign flags never move;
- that reset clears the register.

Only the bench scenarios can show the rest: that specific encodings land in the right class (signed zeros, denormals of both signs, infinities and signed NaNs), that the selector reaches each of the eight registers, and that a write in the same cycle as a read gives the old value. The bench also checks the one-cycle result timing against its own model of the register file.

// File: rtl/fzcmp_pkg.sv
package fzcmp_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = FP_W - EXP_W - 1;
  localparam int ST_W  = 7;

  // status bit positions
  localparam int ST_OVF   = 0;
  localparam int ST_UNF   = 1;
  localparam int ST_NEG   = 2;
  localparam int ST_ZERO  = 3;
  localparam int ST_INEG  = 4;
  localparam int ST_IZERO = 5;
  localparam int ST_TEST  = 6;

  localparam logic [12:0] CMPZ_TAG = 13'b1110_0101_1010_0;

  typedef enum logic [1:0] {CLS_ZERO = 2'd0, CLS_POS = 2'd1, CLS_NEG = 2'd2} cmp_cls_e;

  // zero exponent -> zero (signed zero, denormal); otherwise the sign decides,
  // which also gives NaN the treatment of a signed infinity
  function automatic cmp_cls_e classify(input logic [FP_W-1:0] w);
    logic [EXP_W-1:0] e;
    e = w[FP_W-2 -: EXP_W];
    if (e == '0)          return CLS_ZERO;
    else if (w[FP_W-1])   return CLS_NEG;
    else                  return CLS_POS;
  endfunction
endpackage

// File: rtl/fzcmp_decode.sv
module fzcmp_decode #(
  parameter int OPC_W = 16,
  parameter int SEL_W = 3,
  parameter logic [OPC_W-SEL_W-1:0] TAG = fzcmp_pkg::CMPZ_TAG
) (
  input  logic             instr_valid,
  input  logic [OPC_W-1:0] instr_word,
  output logic             hit,
  output logic [SEL_W-1:0] sel
);
  assign hit = instr_valid && (instr_word[OPC_W-1:SEL_W] == TAG);
  assign sel = instr_word[SEL_W-1:0];
endmodule

// File: rtl/fzcmp_regfile.sv
module fzcmp_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == SEL_W'(g)) regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/fzcmp_classify.sv
module fzcmp_classify
  import fzcmp_pkg::*;
(
  input  logic [FP_W-1:0] operand,
  output cmp_cls_e        cls
);
  assign cls = classify(operand);
endmodule

// File: rtl/fzcmp_unit.sv
module fzcmp_unit
  import fzcmp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int OPC_W    = 16,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_addr,
  input  logic [FP_W-1:0]  wr_data,
  input  logic             instr_valid,
  input  logic [OPC_W-1:0] instr_word,
  output logic [ST_W-1:0]  status_q
);
  logic             op_hit;
  logic [SEL_W-1:0] op_sel;
  logic [FP_W-1:0]  src_word;
  cmp_cls_e         src_cls;
  logic [ST_W-1:0]  st_q;

  fzcmp_decode #(.OPC_W(OPC_W), .SEL_W(SEL_W)) u_dec (
    .instr_valid(instr_valid), .instr_word(instr_word),
    .hit(op_hit), .sel(op_sel));

  fzcmp_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(FP_W)) u_rf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(op_sel), .rd_data(src_word));

  fzcmp_classify u_cls (.operand(src_word), .cls(src_cls));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (op_hit) begin
      st_q[ST_ZERO] <= (src_cls == CLS_ZERO);
      st_q[ST_NEG]  <= (src_cls == CLS_NEG);
    end
  end

  assign status_q = st_q;
endmodule

// File: rtl/fzcmp_checker.sv
module fzcmp_checker
  import fzcmp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [15:0]     instr_word,
  input logic            hit,
  input logic [FP_W-1:0] src_word,
  input logic [ST_W-1:0] status_q
);
  logic src_exp_zero;
  assign src_exp_zero = (src_word[30:23] == 8'h00);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> status_q == '0);

  assert_zero_class_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && src_exp_zero) |=> (status_q[ST_ZERO] && !status_q[ST_NEG]));

  assert_pos_class_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !src_exp_zero && !src_word[31]) |=> (!status_q[ST_ZERO] && !status_q[ST_NEG]));

  assert_neg_class_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !src_exp_zero && src_word[31]) |=> (!status_q[ST_ZERO] && status_q[ST_NEG]));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid || instr_word[15:3] != CMPZ_TAG) |=> $stable(status_q));

  assert_foreign_bits_R6: assert property (@(posedge clk) disable iff (rst)
    hit |=> ($stable({status_q[6:4], status_q[1:0]})));
endmodule

bind fzcmp_unit fzcmp_checker u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .hit(op_hit), .src_word(src_word), .status_q(status_q));

// File: tb/fzcmp_unit_bench.sv
module fzcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [6:0]  status_q;

  int compared = 0;
  int mismatched = 0;
  logic [6:0]  exp_q[$];
  string       tag_q[$];
  logic [6:0]  model_st = '0;
  logic [31:0] model_rf [8];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fzcmp_unit u_fzcmp_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .instr_valid(instr_valid), .instr_word(instr_word), .status_q(status_q));

  // magnitude below the smallest normal counts as zero
  function automatic logic [6:0] apply_cmp(input logic [6:0] st, input logic [31:0] w);
    logic z;
    logic [6:0] r;
    z = (w[30:0] < 31'h0080_0000);
    r = st;
    r[3] = z;
    r[2] = !z && w[31];
    return r;
  endfunction

  task automatic issue(input logic v, input logic [15:0] word, input logic we,
                       input logic [2:0] wa, input logic [31:0] wd, input string tag);
    @(negedge clk);
    instr_valid = v; instr_word = word;
    wr_en = we; wr_addr = wa; wr_data = wd;
    if (v && word[15:3] == 13'b1110_0101_1010_0)
      model_st = apply_cmp(model_st, model_rf[word[2:0]]);
    if (we) model_rf[wa] = wd;
    @(posedge clk);
    #1;
    exp_q.push_back(model_st);
    tag_q.push_back(tag);
  endtask

  task automatic load(input logic [2:0] a, input logic [31:0] d);
    issue(1'b0, 16'h0000, 1'b1, a, d, "R7 write-only cycle");
  endtask

  task automatic cmp(input logic [2:0] a, input string tag);
    issue(1'b1, {13'b1110_0101_1010_0, a}, 1'b0, 3'd0, 32'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; instr_valid = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    #1;
    model_st = '0;
    exp_q.push_back(7'h00);
    tag_q.push_back("R9 reset clears status");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: compare one result per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (status_q !== e) begin
        mismatched++;
        $display("FAIL %s: status actual %b expected %b", t, status_q, e);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    load(3'd0, 32'h40A0_0000);  // +5.0
    load(3'd1, 32'hC000_0000);  // -2.0
    load(3'd2, 32'h0000_0000);  // +0
    load(3'd3, 32'h8000_0000);  // -0
    load(3'd4, 32'h0000_0001);  // +denormal
    load(3'd5, 32'h807F_FFFF);  // -denormal
    load(3'd6, 32'h7FC0_0000);  // +NaN
    load(3'd7, 32'hFFC0_0000);  // -NaN
    cmp(3'd0, "R3 R8 positive finite");
    cmp(3'd1, "R4 negative finite");
    cmp(3'd2, "R2 positive zero");
    cmp(3'd1, "R4 back to negative");
    cmp(3'd3, "R2 negative zero");
    cmp(3'd1, "R4 negative again");
    cmp(3'd4, "R2 positive denormal");
    cmp(3'd1, "R4 negative again");
    cmp(3'd5, "R2 negative denormal");
    cmp(3'd6, "R5 R3 positive NaN");
    cmp(3'd7, "R5 R4 negative NaN");
    // R7: near-miss opcodes and strobe low keep negative flags
    issue(1'b1, 16'hE5A8, 1'b0, 3'd0, 32'h0, "R7 R1 bit3 set mismatch");
    issue(1'b1, 16'hE4A2, 1'b0, 3'd0, 32'h0, "R7 R1 high byte mismatch");
    issue(1'b0, 16'hE5A2, 1'b0, 3'd0, 32'h0, "R7 valid low ignored");
    issue(1'b1, 16'h65A2, 1'b0, 3'd0, 32'h0, "R7 R1 top bit mismatch");
    cmp(3'd2, "R1 R10 exact match executes");
    load(3'd6, 32'h7F80_0000);  // +inf
    load(3'd7, 32'hFF80_0000);  // -inf
    cmp(3'd7, "R4 negative infinity");
    cmp(3'd6, "R3 positive infinity");
    // R10: same-cycle write reads old value, next compare sees new
    issue(1'b1, 16'hE5A0, 1'b1, 3'd0, 32'hC0A0_0000, "R10 read before write");
    cmp(3'd0, "R10 new value visible");
    // R10: smallest normal vs largest denormal
    load(3'd4, 32'h0080_0000);
    cmp(3'd4, "R3 smallest normal is positive");
    load(3'd5, 32'h007F_FFFF);
    cmp(3'd5, "R2 largest denormal is zero");
    cmp(3'd1, "R4 before reset");
    do_reset();
    cmp(3'd0, "R6 R4 foreign bits stay after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule